// File: doc/BRIEF.md
# I2C Register-Write Target

This block is a bus target for a two-wire serial interface that accepts register writes from a bus master. It watches the clock and data lines and resynchronises them to the local system clock. It finds the conditions that open and close a transfer. Once a transfer is open, it collects bytes one bit at a time, with the most significant bit first.

A transfer is meant for this target when the first byte holds the fixed 7-bit device address 0x36 with the direction bit clear. The target then takes a second byte as a register pointer and a third byte as the value to store. After the third byte it emits a one-cycle write strobe, together with the pointer and the value, toward a local register file. Each accepted byte is acknowledged by pulling the data line low for the ninth clock pulse. The data output is a pull-down enable for an open-drain pad. The line is released at all other times.

The system clock must run at least eight times faster than the serial clock.

Top module: `i2c_reg_write_target`

## Requirements
- R1: While reset is held low and after it is released, `sda_pull_o`, `wr_en_o` and `bus_busy_o` are 0.
- R2: Data falling while the serial clock is high (START) sets `bus_busy_o` to 1. Data rising while the serial clock is high (STOP) clears it.
- R3: A first byte of 0x6C (address 0x36, direction bit 0 = write) is acknowledged. `sda_pull_o` is set on the serial clock falling edge after bit 8 and cleared on the falling edge that ends the ninth pulse.
- R4: A first byte whose upper seven bits differ from 0x36 is not acknowledged. The target then leaves the line released for every later byte until the next START or STOP, and issues no write.
- R5: A first byte of 0x6D (direction bit 1 = read) is not acknowledged, and no write follows.
- R6: After an acknowledged address, the second byte is the register pointer and the third byte is the data, both taken MSB first. When the ninth pulse of the third byte ends, `wr_en_o` is high for exactly one system clock, with `wr_addr_o` and `wr_data_o` holding those bytes. Both bytes are acknowledged.
- R7: Any byte that follows the data byte before a STOP or START is not acknowledged and causes no further write.
- R8: A repeated START in the middle of a transfer restarts address reception. The next byte is treated as a device address.
- R9: A STOP before the data byte is complete aborts the transfer without a write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | High to pull the data line low (acknowledge) |
| bus_busy_o | output | 1 | High between START and STOP |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register pointer for the write |
| wr_data_o | output | 8 | Data value for the write |

## Verification
The bench builds the block with the default device address 0x36. It drives the serial clock at one fortieth of the system clock, which leaves ample margin over the eight-to-one minimum. The bench models the open-drain line as a wired AND of the master's drive and the target's pull-down, so acknowledges are read from the shared line just as a master would read them. Because the address parameter is fixed, a single build can exercise a matching address, a neighbouring address, the read direction, a repeated START and an early STOP.

// File: rtl/i2c_reg_write_target.sv
module i2c_reg_write_target #(
  parameter logic [6:0] DEV_ADDR = 7'h36
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic       bus_busy_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_REG, S_DATA, S_SKIP} st_t;

  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q;
  st_t        state;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;

  wire scl      = scl_sync[1];
  wire sda      = sda_sync[1];
  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start_c  = scl & scl_q & sda_q & ~sda;
  wire stop_c   = scl & scl_q & ~sda_q & sda;
  wire addr_ok  = (shreg[7:1] == DEV_ADDR) && !shreg[0];
  wire active   = (state == S_DEV) || (state == S_REG) || (state == S_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sync   <= 2'b11;
      sda_sync   <= 2'b11;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      state      <= S_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      sda_pull_o <= 1'b0;
      bus_busy_o <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl;
      sda_q    <= sda;
      wr_en_o  <= 1'b0;
      if (start_c) begin
        state      <= S_DEV;
        bit_cnt    <= '0;
        sda_pull_o <= 1'b0;
        bus_busy_o <= 1'b1;
      end else if (stop_c) begin
        state      <= S_IDLE;
        bit_cnt    <= '0;
        sda_pull_o <= 1'b0;
        bus_busy_o <= 1'b0;
      end else if (active) begin
        if (scl_rise && bit_cnt < 4'd8) begin
          shreg   <= {shreg[6:0], sda};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall && sda_pull_o) begin
          sda_pull_o <= 1'b0;
          bit_cnt    <= '0;
          case (state)
            S_DEV:   state <= S_REG;
            S_REG:   state <= S_DATA;
            default: begin
              state   <= S_SKIP;
              wr_en_o <= 1'b1;
            end
          endcase
        end else if (scl_fall && bit_cnt == 4'd8) begin
          if (state == S_DEV && !addr_ok) state <= S_SKIP;
          else sda_pull_o <= 1'b1;
          if (state == S_REG)  wr_addr_o <= shreg;
          if (state == S_DATA) wr_data_o <= shreg;
        end
      end
    end
  end

  // R6
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  // R2
  start_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (state == S_DEV && bus_busy_o && !sda_pull_o));

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (state == S_IDLE && !bus_busy_o && !sda_pull_o));

  // R3
  ack_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_q);

  // R4
  nack_bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEV && scl_fall && bit_cnt == 4'd8 && !sda_pull_o && !addr_ok)
      |=> (!sda_pull_o && state == S_SKIP));

endmodule

// File: tb/i2c_reg_write_target_tb.sv
module i2c_reg_write_target_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, busy, wr_en;
  logic [7:0] wr_addr, wr_data;
  wire  sda_line = sda_m & ~sda_pull;

  int checks = 0;
  int fails = 0;
  int strobes = 0;
  logic [7:0] last_addr = '0, last_data = '0;

  always #10 clk = ~clk;

  i2c_reg_write_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .bus_busy_o(busy), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  always @(negedge clk) if (rst_n && wr_en) begin
    strobes++;
    last_addr = wr_addr;
    last_data = wr_data;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    acked = !sda_line;
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic t_reset();
    check(!sda_pull && !wr_en && !busy, "R1", {sda_pull, wr_en, busy}, 0);
  endtask

  task automatic t_good_write();
    bit a;
    int s0 = strobes;
    bus_start();
    check(busy == 1'b1, "R2", busy, 1);
    send_byte(8'h6C, a);  check(a, "R3", a, 1);
    send_byte(8'hA5, a);  check(a, "R6", a, 1);
    send_byte(8'h3C, a);  check(a, "R6", a, 1);
    check(strobes == s0 + 1, "R6", strobes - s0, 1);
    check(last_addr == 8'hA5 && last_data == 8'h3C, "R6", {last_addr, last_data}, 16'hA53C);
    check(!sda_pull, "R3", sda_pull, 0);
    send_byte(8'hFF, a);  check(!a, "R7", a, 0);
    check(strobes == s0 + 1, "R7", strobes - s0, 1);
    bus_stop();
    check(busy == 1'b0, "R2", busy, 0);
  endtask

  task automatic t_bad_addr();
    bit a;
    int s0 = strobes;
    bus_start();
    send_byte(8'h68, a);  check(!a, "R4", a, 0);
    send_byte(8'h12, a);  check(!a, "R4", a, 0);
    send_byte(8'h34, a);  check(!a, "R4", a, 0);
    check(strobes == s0, "R4", strobes - s0, 0);
    bus_stop();
  endtask

  task automatic t_read_dir();
    bit a;
    int s0 = strobes;
    bus_start();
    send_byte(8'h6D, a);  check(!a, "R5", a, 0);
    send_byte(8'h01, a);  check(!a, "R5", a, 0);
    check(strobes == s0, "R5", strobes - s0, 0);
    bus_stop();
  endtask

  task automatic t_restart();
    bit a;
    int s0 = strobes;
    bus_start();
    send_byte(8'h6C, a);
    send_byte(8'h11, a);
    bus_start();
    check(busy == 1'b1, "R8", busy, 1);
    send_byte(8'h6C, a);  check(a, "R8", a, 1);
    send_byte(8'h22, a);
    send_byte(8'h44, a);
    check(strobes == s0 + 1, "R8", strobes - s0, 1);
    check(last_addr == 8'h22 && last_data == 8'h44, "R8", {last_addr, last_data}, 16'h2244);
    bus_stop();
  endtask

  task automatic t_early_stop();
    bit a;
    int s0 = strobes;
    bus_start();
    send_byte(8'h6C, a);
    send_byte(8'h55, a);
    bus_stop();
    wq(4);
    check(strobes == s0, "R9", strobes - s0, 0);
    check(!sda_pull && !busy, "R9", {sda_pull, busy}, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_good_write();
    t_bad_addr();
    t_read_dir();
    t_restart();
    t_early_stop();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule